// File: doc/BRIEF.md
# Dynamic Branch Predictor with Target Buffer

This block predicts the next fetch address for an in-order pipeline. It is a direct-mapped table. Each entry holds a valid flag, an address tag, a 2-bit saturating direction counter and a stored branch target. The entry is selected by the low word-address bits of the program counter.

Each cycle the fetch stage presents its current address and receives two results without delay: a predicted-taken flag and the address to fetch next. When the execute stage resolves a branch, it reports the branch address, the actual direction and the actual target on the update port. The entry for that branch is then trained or newly claimed. The write takes effect at the following clock edge.

An entry that has never been trained gives the sequential address, and so does an entry whose tag belongs to another branch. The front end therefore falls back to fetching in order until real history exists.

Top module: `dyn_branch_pred`

## Requirements
- R1: After reset every entry is invalid, so every lookup reports not taken with a next address of fetch_pc + 4.
- R2: When the prediction is not taken, pred_next equals fetch_pc + INST_BYTES (4 by default).
- R3: When the selected entry is valid, its tag matches and its counter's upper bit is 1, pred_taken is 1 and pred_next equals the stored target.
- R4: The counter encoding is 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken. A taken outcome moves it up and saturates at 11, so after three or more taken updates a single not-taken update still leaves the prediction taken.
- R5: A not-taken outcome moves the counter down and saturates at 00, so after two or more not-taken updates a single taken update still leaves the prediction not taken.
- R6: The first resolution of a branch claims the entry. It sets valid, stores the tag and the target, and loads the counter with 01 whatever the outcome. One taken update therefore still predicts not taken, and a second one predicts taken.
- R7: The index is fetch_pc[7:2] and the tag is fetch_pc[31:8] by default. A lookup whose stored tag differs reports not taken. An update from such an alias reclaims the entry as in R6, which evicts the earlier branch.
- R8: Every update to a matching entry rewrites the stored target with upd_target, including not-taken updates.
- R9: An update and a lookup to the same entry in one cycle give the lookup the old contents. The new contents are visible from the next cycle.
- R10: While upd_en is low, no entry changes, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_pc | input | ADDR_W | Address being fetched this cycle |
| pred_taken | output | 1 | Prediction that the fetched instruction is a taken branch |
| pred_next | output | ADDR_W | Predicted next fetch address |
| upd_en | input | 1 | A branch was resolved in execute this cycle |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual direction of the resolved branch |
| upd_target | input | ADDR_W | Actual target of the resolved branch |

## Verification
The assertions check on every cycle that the history rules hold:
- nothing predicts taken before a taken outcome has been reported;
- two back-to-back taken updates of one branch make it predict taken, toward the last target;
- two back-to-back not-taken updates make it predict not taken;
- the outputs stay still while neither the fetch address nor the tables change.

Only the bench's scenarios can show the following. Saturation at either end needs long update runs. Alias eviction needs a specific pair of addresses. The old-contents result of a colliding read and write, and the rewriting of the target on a not-taken outcome, need cycle-exact stimulus compared against a reference table.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_e;

  // saturating step of a direction counter
  function automatic ctr_e ctr_step(input ctr_e cur, input logic taken);
    ctr_e nxt;
    nxt = cur;
    if (taken) begin
      if (cur != CTR_ST) nxt = ctr_e'(cur + 2'd1);
    end else begin
      if (cur != CTR_SNT) nxt = ctr_e'(cur - 2'd1);
    end
    return nxt;
  endfunction

  function automatic logic ctr_says_taken(input ctr_e c);
    return c[1];
  endfunction

endpackage

// File: rtl/bp_rst_sync.sv
module bp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/bp_store.sv
module bp_store
  import bp_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int TAG_W  = 24,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  // read port for fetch
  input  logic [IDX_W-1:0]  f_idx,
  output logic              f_valid,
  output logic [TAG_W-1:0]  f_tag,
  output ctr_e              f_ctr,
  output logic [ADDR_W-1:0] f_tgt,
  // read port for update
  input  logic [IDX_W-1:0]  u_idx,
  output logic              u_valid,
  output logic [TAG_W-1:0]  u_tag,
  output ctr_e              u_ctr,
  // write port
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  ctr_e              wr_ctr,
  input  logic [ADDR_W-1:0] wr_tgt
);
  logic [DEPTH-1:0]  valid_vec;
  logic [TAG_W-1:0]  tag_arr [DEPTH];
  ctr_e              ctr_arr [DEPTH];
  logic [ADDR_W-1:0] tgt_arr [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic              sel;
    logic              v_q,  v_d;
    logic [TAG_W-1:0]  t_q,  t_d;
    ctr_e              c_q,  c_d;
    logic [ADDR_W-1:0] g_q,  g_d;

    assign sel = wr_en && (wr_idx == IDX_W'(i));

    always_comb begin
      v_d = v_q;
      t_d = t_q;
      c_d = c_q;
      g_d = g_q;
      if (sel) begin
        v_d = 1'b1;
        t_d = wr_tag;
        c_d = wr_ctr;
        g_d = wr_tgt;
      end
    end

    // valid flag is the only reset state
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q <= 1'b0;
      else        v_q <= v_d;
    end

    // payload: enabled, not reset
    always_ff @(posedge clk) begin
      if (sel) begin
        t_q <= t_d;
        c_q <= c_d;
        g_q <= g_d;
      end
    end

    assign valid_vec[i] = v_q;
    assign tag_arr[i]   = t_q;
    assign ctr_arr[i]   = c_q;
    assign tgt_arr[i]   = g_q;
  end

  always_comb begin
    f_valid = valid_vec[f_idx];
    f_tag   = tag_arr[f_idx];
    f_ctr   = ctr_arr[f_idx];
    f_tgt   = tgt_arr[f_idx];
    u_valid = valid_vec[u_idx];
    u_tag   = tag_arr[u_idx];
    u_ctr   = ctr_arr[u_idx];
  end
endmodule

// File: rtl/bp_update_ctl.sv
module bp_update_ctl
  import bp_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int TAG_W  = 24,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              upd_en,
  input  logic              upd_taken,
  input  logic [IDX_W-1:0]  upd_idx,
  input  logic [TAG_W-1:0]  upd_tag,
  input  logic [ADDR_W-1:0] upd_target,
  input  logic              cur_valid,
  input  logic [TAG_W-1:0]  cur_tag,
  input  ctr_e              cur_ctr,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [TAG_W-1:0]  wr_tag,
  output ctr_e              wr_ctr,
  output logic [ADDR_W-1:0] wr_tgt
);
  logic owned;

  always_comb begin
    owned  = cur_valid && (cur_tag == upd_tag);
    wr_en  = upd_en;
    wr_idx = upd_idx;
    wr_tag = upd_tag;
    wr_tgt = upd_target;
    // a fresh claim starts weak not-taken; a trained entry steps
    wr_ctr = owned ? ctr_step(cur_ctr, upd_taken) : CTR_WNT;
  end
endmodule

// File: rtl/bp_lookup.sv
module bp_lookup
  import bp_pkg::*;
#(
  parameter int TAG_W      = 24,
  parameter int ADDR_W     = 32,
  parameter int INST_BYTES = 4
) (
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic [TAG_W-1:0]  fetch_tag,
  input  logic              ent_valid,
  input  logic [TAG_W-1:0]  ent_tag,
  input  ctr_e              ent_ctr,
  input  logic [ADDR_W-1:0] ent_tgt,
  output logic              pred_taken,
  output logic [ADDR_W-1:0] pred_next
);
  logic hit;

  always_comb begin
    hit        = ent_valid && (ent_tag == fetch_tag);
    pred_taken = hit && ctr_says_taken(ent_ctr);
    pred_next  = pred_taken ? ent_tgt : (fetch_pc + ADDR_W'(INST_BYTES));
  end
endmodule

// File: rtl/dyn_branch_pred.sv
module dyn_branch_pred
  import bp_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DEPTH      = 64,
  parameter int INST_BYTES = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic              pred_taken,
  output logic [ADDR_W-1:0] pred_next,
  input  logic              upd_en,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic              upd_taken,
  input  logic [ADDR_W-1:0] upd_target
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int OFS_W = $clog2(INST_BYTES);
  localparam int TAG_W = ADDR_W - IDX_W - OFS_W;

  logic              rst_sync_n;
  logic [IDX_W-1:0]  f_idx, u_idx;
  logic [TAG_W-1:0]  f_tagq, u_tagq;
  logic              f_valid, u_valid;
  logic [TAG_W-1:0]  f_tag, u_tag;
  ctr_e              f_ctr, u_ctr;
  logic [ADDR_W-1:0] f_tgt;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [TAG_W-1:0]  wr_tag;
  ctr_e              wr_ctr;
  logic [ADDR_W-1:0] wr_tgt;

  assign f_idx  = fetch_pc[OFS_W +: IDX_W];
  assign f_tagq = fetch_pc[ADDR_W-1 -: TAG_W];
  assign u_idx  = upd_pc[OFS_W +: IDX_W];
  assign u_tagq = upd_pc[ADDR_W-1 -: TAG_W];

  bp_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  bp_store #(.DEPTH(DEPTH), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_sync_n),
    .f_idx(f_idx), .f_valid(f_valid), .f_tag(f_tag), .f_ctr(f_ctr), .f_tgt(f_tgt),
    .u_idx(u_idx), .u_valid(u_valid), .u_tag(u_tag), .u_ctr(u_ctr),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_ctr(wr_ctr), .wr_tgt(wr_tgt)
  );

  bp_update_ctl #(.DEPTH(DEPTH), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_upd (
    .upd_en(upd_en), .upd_taken(upd_taken), .upd_idx(u_idx), .upd_tag(u_tagq),
    .upd_target(upd_target), .cur_valid(u_valid), .cur_tag(u_tag), .cur_ctr(u_ctr),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_ctr(wr_ctr), .wr_tgt(wr_tgt)
  );

  bp_lookup #(.TAG_W(TAG_W), .ADDR_W(ADDR_W), .INST_BYTES(INST_BYTES)) u_look (
    .fetch_pc(fetch_pc), .fetch_tag(f_tagq), .ent_valid(f_valid), .ent_tag(f_tag),
    .ent_ctr(f_ctr), .ent_tgt(f_tgt), .pred_taken(pred_taken), .pred_next(pred_next)
  );
endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] fetch_pc,
  input logic              pred_taken,
  input logic [ADDR_W-1:0] pred_next,
  input logic              upd_en,
  input logic [ADDR_W-1:0] upd_pc,
  input logic              upd_taken,
  input logic [ADDR_W-1:0] upd_target
);
  logic [2:0] cyc;
  logic       seen_taken;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc        <= '0;
      seen_taken <= 1'b0;
    end else begin
      if (cyc != 3'd7) cyc <= cyc + 3'd1;
      if (upd_en && upd_taken) seen_taken <= 1'b1;
    end
  end

  // R1: no taken prediction before any taken outcome was reported
  a_r1_no_taken_untrained: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_taken |-> !pred_taken);

  // R6: two back-to-back taken updates of one branch make it predict taken
  a_r6_two_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 3'd5 && $past(upd_en, 2) && $past(upd_taken, 2) && $past(upd_en) &&
     $past(upd_taken) && $past(upd_pc) == $past(upd_pc, 2) && fetch_pc == $past(upd_pc))
    |-> (pred_taken && pred_next == $past(upd_target)));

  // R5: two back-to-back not-taken updates make it predict not taken
  a_r5_two_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 3'd5 && $past(upd_en, 2) && !$past(upd_taken, 2) && $past(upd_en) &&
     !$past(upd_taken) && $past(upd_pc) == $past(upd_pc, 2) && fetch_pc == $past(upd_pc))
    |-> !pred_taken);

  // R10: outputs hold while no update arrived and the fetch address is unchanged
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 3'd2 && !$past(upd_en) && $stable(fetch_pc))
    |-> ($stable(pred_taken) && $stable(pred_next)));
endmodule

bind dyn_branch_pred bp_checker #(.ADDR_W(ADDR_W)) u_bp_checker (
  .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_taken(pred_taken),
  .pred_next(pred_next), .upd_en(upd_en), .upd_pc(upd_pc),
  .upd_taken(upd_taken), .upd_target(upd_target)
);

// File: tb/sim_dyn_branch_pred.sv
`timescale 1ns/1ps
module sim_dyn_branch_pred;
  localparam int AW = 32;
  localparam int NENT = 64;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] fetch_pc;
  logic          pred_taken;
  logic [AW-1:0] pred_next;
  logic          upd_en;
  logic [AW-1:0] upd_pc;
  logic          upd_taken;
  logic [AW-1:0] upd_target;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  // reference table built from the requirements
  bit        m_valid [NENT];
  bit [23:0] m_tag   [NENT];
  bit [1:0]  m_ctr   [NENT];
  bit [31:0] m_tgt   [NENT];

  dyn_branch_pred u0 (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_taken(pred_taken),
    .pred_next(pred_next), .upd_en(upd_en), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_target(upd_target)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int ix(input bit [31:0] pc);
    return int'(pc[7:2]);
  endfunction

  function automatic bit exp_taken(input bit [31:0] pc);
    int i;
    i = ix(pc);
    return m_valid[i] && (m_tag[i] == pc[31:8]) && m_ctr[i][1];
  endfunction

  function automatic bit [31:0] exp_next(input bit [31:0] pc);
    return exp_taken(pc) ? m_tgt[ix(pc)] : pc + 32'd4;
  endfunction

  task automatic model_update(input bit [31:0] pc, input bit tk, input bit [31:0] tg);
    int i;
    i = ix(pc);
    if (m_valid[i] && m_tag[i] == pc[31:8]) begin
      if (tk && m_ctr[i] != 2'b11) m_ctr[i] = m_ctr[i] + 2'd1;
      if (!tk && m_ctr[i] != 2'b00) m_ctr[i] = m_ctr[i] - 2'd1;
    end else begin
      m_valid[i] = 1'b1;
      m_tag[i]   = pc[31:8];
      m_ctr[i]   = 2'b01;
    end
    m_tgt[i] = tg;
  endtask

  task automatic report;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // one cycle: drive at negedge, check before the edge, then model the edge
  task automatic step(input bit [31:0] fpc, input bit ue, input bit [31:0] upc,
                      input bit ut, input bit [31:0] utg, input string req);
    bit        et;
    bit [31:0] en;
    @(negedge clk);
    fetch_pc = fpc; upd_en = ue; upd_pc = upc; upd_taken = ut; upd_target = utg;
    #1;
    et = exp_taken(fpc);
    en = exp_next(fpc);
    n_run++;
    if (pred_taken !== et || pred_next !== en) begin
      n_fail++;
      $display("FAIL %s pc=%h taken=%0b/%h expected %0b/%h",
               req, fpc, pred_taken, pred_next, et, en);
    end
    @(posedge clk);
    if (ue) model_update(upc, ut, utg);
  endtask

  task automatic look(input bit [31:0] fpc, input string req);
    step(fpc, 1'b0, 32'h0, 1'b0, 32'h0, req);
  endtask

  task automatic train(input bit [31:0] pc, input bit tk, input bit [31:0] tg, input string req);
    step(32'h0000_0f00, 1'b1, pc, tk, tg, req);
  endtask

  initial begin
    #(10 * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    bit [31:0] pool [8];
    bit [31:0] A, B, C, D;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NENT; i++) begin
      m_valid[i] = 0; m_tag[i] = '0; m_ctr[i] = '0; m_tgt[i] = '0;
    end
    rst_n = 0; fetch_pc = '0; upd_en = 0; upd_pc = '0; upd_taken = 0; upd_target = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1: untrained lookups after reset are sequential
    look(32'h0000_1000, "R1");
    look(32'h0000_2044, "R1");
    look(32'hFFFF_FFFC, "R1");
    look(32'h0000_0000, "R1");

    A = 32'h0000_1010; B = A + 32'h100; C = 32'h0000_3020; D = 32'h0000_4034;

    // R6: first taken update claims weak not-taken, second predicts taken
    train(A, 1, 32'h0000_5000, "R6");
    look(A, "R6");
    train(A, 1, 32'h0000_5000, "R6");
    look(A, "R3");
    // R4: saturate at strong taken, one not-taken keeps taken
    train(A, 1, 32'h0000_5000, "R4");
    train(A, 1, 32'h0000_5000, "R4");
    train(A, 1, 32'h0000_5000, "R4");
    train(A, 0, 32'h0000_5000, "R4");
    look(A, "R4");
    train(A, 0, 32'h0000_5000, "R4");
    look(A, "R4");
    // R5: saturate at strong not-taken, one taken keeps not taken
    train(A, 0, 32'h0000_5000, "R5");
    train(A, 0, 32'h0000_5000, "R5");
    train(A, 1, 32'h0000_5000, "R5");
    look(A, "R5");
    // R7: alias shares the index, differing tag misses and then evicts
    train(A, 1, 32'h0000_5000, "R7");
    train(A, 1, 32'h0000_5000, "R7");
    look(A, "R7");
    look(B, "R7");
    train(B, 1, 32'h0000_6000, "R7");
    train(B, 1, 32'h0000_6000, "R7");
    look(B, "R7");
    look(A, "R7");
    // R8: not-taken update rewrites the target of a taken entry
    train(C, 1, 32'h0000_7000, "R8");
    train(C, 1, 32'h0000_7000, "R8");
    train(C, 1, 32'h0000_7000, "R8");
    train(C, 0, 32'h0000_7400, "R8");
    look(C, "R8");
    // R9: same-cycle update and lookup see old contents
    train(D, 1, 32'h0000_8000, "R9");
    step(D, 1'b1, D, 1'b1, 32'h0000_8000, "R9");
    look(D, "R9");
    // R10: update inputs are ignored while upd_en is low
    step(D, 1'b0, D, 1'b0, 32'h0000_9999, "R10");
    step(D, 1'b0, D, 1'b0, 32'h0000_9999, "R10");
    step(D, 1'b0, D, 1'b0, 32'h0000_9999, "R10");
    look(D, "R10");

    // R2 / R3: random traffic over a pool with aliasing pairs
    for (int k = 0; k < 4; k++) begin
      pool[k]     = 32'h0000_1800 + 32'(k) * 32'd4;
      pool[k + 4] = pool[k] + 32'h0000_0100;
    end
    for (int n = 0; n < 600; n++) begin
      bit [31:0] f, u, t;
      bit        ue, tk;
      f  = pool[$urandom_range(0, 7)];
      u  = pool[$urandom_range(0, 7)];
      ue = ($urandom_range(0, 3) != 0);
      tk = ($urandom_range(0, 2) != 0);
      t  = {$urandom_range(0, 32'h3fff_ffff), 2'b00};
      step(f, ue, u, tk, t, exp_taken(f) ? "R3" : "R2");
    end

    finished = 1;
    report();
  end
endmodule